// File: doc/BRIEF.md
# Input Buffer Swap Controller

This block sits inside one router of a two-dimensional mesh and keeps every incoming link in service after an input buffer fails. A diagnosis unit supplies one fault bit per input port. When a port's buffer goes bad, the controller lends that link the input buffer of another port. The lending port's own link is then shut. The router needs no spare buffers and no extra virtual channels.

Each handover runs through three phases: idle, warn and open. In the warn phase the controller picks the substitute buffer. It sends a one-cycle token to the neighbour behind the lending port and freezes both affected links. It then waits until the substitute buffer holds no packet. In the open phase it writes the remap table entry and opens the link of the faulty port, so the packet held at that neighbour flows into the borrowed buffer. The controller then returns to idle and serves the next fault. Faults are served one at a time.

For each port the controller drives a clear-to-send bit and a port status bit toward the neighbour. It also drives a remap table that the datapath uses to steer writes from each link into a physical buffer.

Top module: `buf_swap_ctrl`

## Requirements
- R1: After a synchronous active-low reset the outputs take these values: phase is idle (code 0), the token is all zero, the port status is all zero, the unrecoverable flag is 0, and clear-to-send is all ones while no fault is present. The remap table is the identity, with each entry of 3 bits at bits [3p+2:3p] for port p. Port indices are north 0, east 1, south 2, west 3, local 4.
- R2: A port whose buffer fault bit is set and which has no substitute yet has clear-to-send 0 in the same cycle the fault bit is seen.
- R3: The substitute is the lowest-index port that meets three conditions: its buffer is not faulty, it is not already lending its buffer, and it is not the faulty port itself. Thus a north fault is served by east, and a local fault by north. When several faults are pending, the lowest-index one is served first.
- R4: On the clock edge that enters the warn phase (code 1), the token output carries a one-hot pulse on the substitute port for exactly one cycle. From that cycle on, clear-to-send of both the substitute port and the faulty port is 0.
- R5: The controller stays in the warn phase, with the remap table unchanged, for as long as the substitute port's buffer-idle input is 0.
- R6: On the first edge with the substitute buffer idle, the phase becomes open (code 2) and the remap entry of the faulty port takes the substitute's index. One cycle later the phase returns to idle.
- R7: A fault that appears during a handover is not started until the controller is back in idle. A port that lends its buffer is never chosen again.
- R8: If a pending fault has no eligible substitute, the controller stays idle, emits no token and leaves the remap table unchanged. It sets the unrecoverable flag, which holds until reset, and then goes on to any later fault.
- R9: Outside the warn phase, clear-to-send of a port is 1 in exactly two cases: the port's buffer is healthy and not lent, or the port has been given a substitute.
- R10: The port status bit of a port is 1 exactly when its link has been remapped to another port's buffer, starting in the open phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| buf_fault_i | input | 5 | Per-port input buffer fault flags from diagnosis, assumed to stay set once raised |
| buf_idle_i | input | 5 | Per-port flag: buffer holds no flits and no packet is open |
| cts_o | output | 5 | Per-link clear-to-send toward the neighbour |
| cps_o | output | 5 | Per-link status: 1 when the link is steered to a borrowed buffer |
| token_o | output | 5 | One-cycle traffic-control token toward the neighbour of the lending port |
| remap_o | output | 15 | Remap table, 3 bits per logical port, giving the physical buffer index |
| phase_o | output | 2 | Handover phase: 0 idle, 1 warn, 2 open |
| unrecoverable_o | output | 1 | Sticky flag: a fault could not be given a substitute |

## Verification
Two functions can meet in one cycle. The substitute buffer can finish draining in the same cycle that the diagnosis unit raises a new fault. A new fault can also appear while a handover is waiting in the warn phase. The bench raises a west fault while a north handover is held by a busy east buffer. It then releases the drain. It judges the result by checking two things. The west fault produces no token until the north handover has passed through open and back to idle. The west fault is then served by south, because east is already lending its buffer. The final remap table and the clear-to-send pattern are compared with values worked out by hand.

// File: rtl/buf_swap_pkg.sv
// Shared types and helpers for the input buffer swap controller.
// Assumes at most 32 ports, which is enough for any mesh router.
package buf_swap_pkg;

    // Handover phase; the codes are visible on phase_o.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WARN = 2'd1,
        PH_OPEN = 2'd2
    } swap_phase_e;

    // Encode a one-hot vector into the index of its set bit (0 if none).
    function automatic int unsigned oh_to_int(input logic [31:0] oh);
        int unsigned r;
        r = 0;
        for (int i = 0; i < 32; i++) begin
            if (oh[i]) r = i;
        end
        return r;
    endfunction

endpackage

// File: rtl/first_one.sv
// Fixed-priority selector: grants the lowest-index set bit of req.
// Assumes nothing about req; found is 0 when req is all zero.
module first_one #(
    parameter int W = 5
) (
    input  logic [W-1:0] req,
    output logic [W-1:0] grant,
    output logic         found
);
    logic [W:0] seen;

    assign seen[0] = 1'b0;

    // Build the "a lower bit already won" chain one bit at a time.
    for (genvar i = 0; i < W; i++) begin : g_chain
        assign grant[i]  = req[i] & ~seen[i];
        assign seen[i+1] = seen[i] | req[i];
    end

    assign found = seen[W];
endmodule

// File: rtl/swap_select.sv
// Chooses the next fault to serve and its substitute buffer.
// Faults are taken lowest index first. A substitute must be healthy,
// must not already lend its buffer and must not be the faulty port.
module swap_select #(
    parameter int N = 5
) (
    input  logic [N-1:0] fault_vec,
    input  logic [N-1:0] served,
    input  logic [N-1:0] given_up,
    input  logic [N-1:0] donor,
    output logic [N-1:0] fault_oh,
    output logic         fault_found,
    output logic [N-1:0] sub_oh,
    output logic         sub_found
);
    logic [N-1:0] pending;
    logic [N-1:0] cand;

    // Faults still waiting for a substitute.
    assign pending = fault_vec & ~served & ~given_up;
    // Buffers that may still be lent to the chosen fault.
    assign cand    = ~fault_vec & ~donor & ~fault_oh;

    first_one #(.W(N)) u_pick_fault (
        .req   (pending),
        .grant (fault_oh),
        .found (fault_found)
    );

    first_one #(.W(N)) u_pick_sub (
        .req   (cand),
        .grant (sub_oh),
        .found (sub_found)
    );
endmodule

// File: rtl/swap_fsm.sv
// Three-phase handover sequencer and owner of the remap table.
// Assumes fault bits stay set once raised and buf_idle is exact.
module swap_fsm
    import buf_swap_pkg::*;
#(
    parameter int N  = 5,
    parameter int IW = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         fault_oh,
    input  logic                 fault_found,
    input  logic [N-1:0]         sub_oh,
    input  logic                 sub_found,
    input  logic [N-1:0]         buf_idle,
    output swap_phase_e          phase,
    output logic [N-1:0]         cur_fault_oh,
    output logic [N-1:0]         cur_sub_oh,
    output logic [N-1:0]         served,
    output logic [N-1:0]         donor,
    output logic [N-1:0]         given_up,
    output logic [N-1:0]         token,
    output logic                 unrec,
    output logic [N*IW-1:0]      remap_flat
);
    logic [IW-1:0] remap_q [N];
    logic [IW-1:0] cur_sub_idx;
    logic          sub_drained;

    // Index of the current substitute, written into the remap table.
    assign cur_sub_idx = IW'(oh_to_int(32'(cur_sub_oh)));
    // The substitute buffer holds no packet.
    assign sub_drained = |(buf_idle & cur_sub_oh);

    // Flatten the remap table onto the output bus.
    for (genvar p = 0; p < N; p++) begin : g_flat
        assign remap_flat[p*IW +: IW] = remap_q[p];
    end

    // Sequence idle -> warn -> open -> idle and record each swap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase        <= PH_IDLE;
            cur_fault_oh <= '0;
            cur_sub_oh   <= '0;
            served       <= '0;
            donor        <= '0;
            given_up     <= '0;
            token        <= '0;
            unrec        <= 1'b0;
            for (int p = 0; p < N; p++) remap_q[p] <= IW'(p);
        end else begin
            token <= '0;
            case (phase)
                PH_IDLE: begin
                    if (fault_found) begin
                        if (sub_found) begin
                            phase        <= PH_WARN;
                            cur_fault_oh <= fault_oh;
                            cur_sub_oh   <= sub_oh;
                            token        <= sub_oh;
                        end else begin
                            given_up <= given_up | fault_oh;
                            unrec    <= 1'b1;
                        end
                    end
                end
                PH_WARN: begin
                    if (sub_drained) begin
                        phase  <= PH_OPEN;
                        served <= served | cur_fault_oh;
                        donor  <= donor | cur_sub_oh;
                        for (int p = 0; p < N; p++) begin
                            if (cur_fault_oh[p]) remap_q[p] <= cur_sub_idx;
                        end
                    end
                end
                PH_OPEN: phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/link_status.sv
// Derives the per-link clear-to-send and port status bits.
// Assumes served and donor come from the sequencer and fault_vec from
// diagnosis; the faulty and lending links stay frozen during warn.
module link_status
    import buf_swap_pkg::*;
#(
    parameter int N = 5
) (
    input  swap_phase_e  phase,
    input  logic [N-1:0] fault_vec,
    input  logic [N-1:0] served,
    input  logic [N-1:0] donor,
    input  logic [N-1:0] cur_fault_oh,
    input  logic [N-1:0] cur_sub_oh,
    output logic [N-1:0] cts,
    output logic [N-1:0] cps
);
    logic [N-1:0] usable;
    logic [N-1:0] frozen;

    // A link may carry flits if its own buffer is fine or it borrows one.
    assign usable = (~fault_vec & ~donor) | served;
    // Both links touched by the ongoing handover are held during warn.
    assign frozen = (phase == PH_WARN) ? (cur_fault_oh | cur_sub_oh) : '0;

    // Combine usability and freeze into the per-link send permission.
    always_comb begin
        cts = usable & ~frozen;
        cps = served;
    end
endmodule

// File: rtl/buf_swap_ctrl.sv
// Top of the input buffer swap controller for one mesh router.
// Ties the selector, the sequencer and the link status logic together.
// Assumes one handover at a time and permanent (sticky) fault bits.
module buf_swap_ctrl
    import buf_swap_pkg::*;
#(
    parameter int N  = 5,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    buf_fault_i,
    input  logic [N-1:0]    buf_idle_i,
    output logic [N-1:0]    cts_o,
    output logic [N-1:0]    cps_o,
    output logic [N-1:0]    token_o,
    output logic [N*IW-1:0] remap_o,
    output logic [1:0]      phase_o,
    output logic            unrecoverable_o
);
    swap_phase_e  phase_w;
    logic [N-1:0] fault_oh_w;
    logic         fault_found_w;
    logic [N-1:0] sub_oh_w;
    logic         sub_found_w;
    logic [N-1:0] cur_fault_oh_w;
    logic [N-1:0] cur_sub_oh_w;
    logic [N-1:0] served_w;
    logic [N-1:0] donor_w;
    logic [N-1:0] given_up_w;

    swap_select #(.N(N)) u_select (
        .fault_vec   (buf_fault_i),
        .served      (served_w),
        .given_up    (given_up_w),
        .donor       (donor_w),
        .fault_oh    (fault_oh_w),
        .fault_found (fault_found_w),
        .sub_oh      (sub_oh_w),
        .sub_found   (sub_found_w)
    );

    swap_fsm #(.N(N), .IW(IW)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .fault_oh     (fault_oh_w),
        .fault_found  (fault_found_w),
        .sub_oh       (sub_oh_w),
        .sub_found    (sub_found_w),
        .buf_idle     (buf_idle_i),
        .phase        (phase_w),
        .cur_fault_oh (cur_fault_oh_w),
        .cur_sub_oh   (cur_sub_oh_w),
        .served       (served_w),
        .donor        (donor_w),
        .given_up     (given_up_w),
        .token        (token_o),
        .unrec        (unrecoverable_o),
        .remap_flat   (remap_o)
    );

    link_status #(.N(N)) u_link (
        .phase        (phase_w),
        .fault_vec    (buf_fault_i),
        .served       (served_w),
        .donor        (donor_w),
        .cur_fault_oh (cur_fault_oh_w),
        .cur_sub_oh   (cur_sub_oh_w),
        .cts          (cts_o),
        .cps          (cps_o)
    );

    assign phase_o = phase_w;
endmodule

// File: rtl/buf_swap_ctrl_chk.sv
// Protocol checker for buf_swap_ctrl, attached by the bind below.
// Watches the ports plus the current substitute held by the sequencer.
module buf_swap_ctrl_chk #(
    parameter int N  = 5,
    parameter int IW = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      phase,
    input logic [N-1:0]    buf_idle,
    input logic [N-1:0]    cur_sub_oh,
    input logic [N-1:0]    token,
    input logic [N-1:0]    cts,
    input logic [N*IW-1:0] remap,
    input logic            unrec
);
    AST_TOKEN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(token)); // R4

    AST_TOKEN_ONLY_IN_WARN: assert property (@(posedge clk) disable iff (!rst_n)
        (token != '0) |-> (phase == 2'd1)); // R4

    AST_TOKEN_LINK_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
        (token != '0) |-> ((cts & token) == '0)); // R4

    AST_TOKEN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (token != '0) |=> (token == '0)); // R4

    AST_HOLD_UNTIL_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd1 && (buf_idle & cur_sub_oh) == '0) |=> (phase == 2'd1)); // R5

    AST_OPEN_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd2) |=> (phase == 2'd0)); // R6

    AST_REMAP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != 2'd1) |=> $stable(remap)); // R5

    AST_UNREC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        unrec |=> unrec); // R8
endmodule

bind buf_swap_ctrl buf_swap_ctrl_chk #(.N(N), .IW(IW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase      (phase_o),
    .buf_idle   (buf_idle_i),
    .cur_sub_oh (cur_sub_oh_w),
    .token      (token_o),
    .cts        (cts_o),
    .remap      (remap_o),
    .unrec      (unrecoverable_o)
);

// File: tb/buf_swap_ctrl_bench.sv
`timescale 1ns/1ps
module buf_swap_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  fault;
    logic [4:0]  idle;
    logic [4:0]  cts, cps, token;
    logic [14:0] remap;
    logic [1:0]  phase;
    logic        unrec;
    int          checks = 0;
    int          errors = 0;
    bit          done = 0;

    always #5 clk = ~clk;

    buf_swap_ctrl u_buf_swap_ctrl (
        .clk(clk), .rst_n(rst_n), .buf_fault_i(fault), .buf_idle_i(idle),
        .cts_o(cts), .cps_o(cps), .token_o(token), .remap_o(remap),
        .phase_o(phase), .unrecoverable_o(unrec)
    );

    function automatic logic [14:0] pack(int e0, int e1, int e2, int e3, int e4);
        return {3'(e4), 3'(e3), 3'(e2), 3'(e1), 3'(e0)};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Advance one clock and sample 1 ns after the edge.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; fault = '0; idle = '1;
        repeat (2) tick();
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 phase", 32'(phase), 0);
        chk("R1 cts", 32'(cts), 32'h1f);
        chk("R1 cps", 32'(cps), 0);
        chk("R1 token", 32'(token), 0);
        chk("R1 remap", 32'(remap), 32'(pack(0,1,2,3,4)));
        chk("R1 unrec", 32'(unrec), 0);
    endtask

    task automatic t_north();
        do_reset();
        fault = 5'b00001;
        #1;
        chk("R2 cts pending", 32'(cts), 32'b11110);
        tick();
        chk("R4 phase warn", 32'(phase), 1);
        chk("R3 token east", 32'(token), 32'b00010);
        chk("R4 cts frozen", 32'(cts), 32'b11100);
        tick();
        chk("R6 phase open", 32'(phase), 2);
        chk("R4 token one cycle", 32'(token), 0);
        chk("R6 remap", 32'(remap), 32'(pack(1,1,2,3,4)));
        chk("R9 cts", 32'(cts), 32'b11101);
        chk("R10 cps", 32'(cps), 32'b00001);
        tick();
        chk("R6 back idle", 32'(phase), 0);
    endtask

    task automatic t_drain_overlap();
        do_reset();
        idle = 5'b11101;
        fault = 5'b00001;
        tick();
        chk("R4 token", 32'(token), 32'b00010);
        fault = 5'b01001;
        repeat (3) tick();
        chk("R5 hold warn", 32'(phase), 1);
        chk("R5 remap unchanged", 32'(remap), 32'(pack(0,1,2,3,4)));
        chk("R7 no token mid handover", 32'(token), 0);
        idle = '1;
        tick();
        chk("R6 open after drain", 32'(phase), 2);
        tick();
        chk("R7 idle before west", 32'(phase), 0);
        chk("R7 token none", 32'(token), 0);
        tick();
        chk("R7 west to south", 32'(token), 32'b00100);
        tick(); tick();
        chk("R7 remap", 32'(remap), 32'(pack(1,1,2,2,4)));
        chk("R9 cts", 32'(cts), 32'b11001);
        chk("R10 cps", 32'(cps), 32'b01001);
    endtask

    task automatic t_two_faults();
        do_reset();
        fault = 5'b00101;
        tick();
        chk("R3 first north", 32'(token), 32'b00010);
        repeat (3) tick();
        chk("R7 south gets west", 32'(token), 32'b01000);
        tick(); tick();
        chk("R7 remap", 32'(remap), 32'(pack(1,1,3,3,4)));
        chk("R9 cts", 32'(cts), 32'b10101);
        chk("R10 cps", 32'(cps), 32'b00101);
        chk("R8 unrec clear", 32'(unrec), 0);
    endtask

    task automatic t_exhaust();
        do_reset();
        fault = 5'b01111;
        tick();
        chk("R3 north gets local", 32'(token), 32'b10000);
        repeat (7) tick();
        chk("R8 unrec", 32'(unrec), 1);
        chk("R8 idle", 32'(phase), 0);
        chk("R8 token", 32'(token), 0);
        chk("R8 remap", 32'(remap), 32'(pack(4,1,2,3,4)));
        chk("R9 cts", 32'(cts), 32'b00001);
        repeat (4) tick();
        chk("R8 sticky", 32'(unrec), 1);
    endtask

    task automatic t_local();
        do_reset();
        fault = 5'b10000;
        tick();
        chk("R3 local gets north", 32'(token), 32'b00001);
        tick(); tick();
        chk("R6 remap", 32'(remap), 32'(pack(0,1,2,3,0)));
        chk("R9 cts", 32'(cts), 32'b11110);
        chk("R10 cps", 32'(cps), 32'b10000);
    endtask

    initial begin
        t_reset();
        t_north();
        t_drain_overlap();
        t_two_faults();
        t_exhaust();
        t_local();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule